// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block holds the protection state of a serial byte-addressed nonvolatile memory: a write-enable latch, a two-bit protected-region selector and a bit that arms the active-low hardware protect pin. From these, the pin level and the busy flag coming from the write-cycle timer, it forms the status byte returned to a status-read command. It also answers two questions for the command decoder: may the status register be written now, and may the array address presented on `chk_addr_i` be written now.

A status-register write is a two-step affair. While the command is being shifted in (`wrsr_open_i` high), the block watches the protect pin. When the command closes (`wrsr_go_i`), it either accepts the write, pulsing `wrsr_start_o` so that the caller launches a timed write cycle, or drops it. Accepted bits are held pending and take effect when that cycle ends (falling edge of `busy_i`). The end of any write cycle also clears the write-enable latch. The retained bits are modelled as ordinary flops that reset to zero.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte is 0x00, and both `sr_wr_ok_o` and `arr_wr_ok_o` are 0.
- R2: When idle the status byte is {protect-arm bit, 3'b000, region bits [1:0], write-enable, 1'b0}: bit 7 arm, bits 3:2 region, bit 1 write-enable, bits 6:4 and bit 0 zero.
- R3: While `busy_i` is 1 the status byte is 0xFF and neither write-allowed output is 1.
- R4: When not busy, `wren_i` sets the write-enable latch and `wrdi_i` clears it, whatever the protect pin level; `wrdi_i` wins if both are given.
- R5: The falling edge of `busy_i` clears the write-enable latch.
- R6: Region code 00 protects nothing, 01 protects addresses whose two top bits are 11 (top quarter), 10 protects addresses whose top bit is 1 (top half), 11 protects every address; `arr_wr_ok_o` = write-enable and not busy and address not protected. Address width is the parameter `ADDR_W`.
- R7: Hardware protection is in force exactly when the arm bit is 1 and `wp_n_i` is 0; it forces `sr_wr_ok_o` to 0 but leaves unprotected array addresses writable.
- R8: `sr_wr_ok_o` = write-enable and not busy and no hardware protection. `wrsr_start_o` is 1 in a cycle with `wrsr_go_i` only if `sr_wr_ok_o` is 1 and the command was not cancelled; data bits 7, 3 and 2 are applied at the next falling edge of `busy_i`, not before.
- R9: If hardware protection is in force in any cycle while `wrsr_open_i` is 1, the following `wrsr_go_i` is rejected even if the pin has returned high.
- R10: Once a status write has been accepted, the protect pin has no effect on it: the pending bits are applied at cycle end even if `wp_n_i` is low by then.
- R11: While the arm bit is 1 and `wp_n_i` is 0, a status write that would clear the arm bit is rejected and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Set write-enable latch (one-cycle strobe) |
| wrdi_i | input | 1 | Clear write-enable latch (one-cycle strobe) |
| wrsr_open_i | input | 1 | A status-write command is being received |
| wrsr_go_i | input | 1 | Status-write command complete, data valid (one-cycle strobe) |
| wrsr_data_i | input | 8 | Status-write data byte |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| busy_i | input | 1 | Timed write cycle in progress |
| chk_addr_i | input | ADDR_W | Array address to check |
| status_o | output | 8 | Status byte |
| sr_wr_ok_o | output | 1 | Status register may be written now |
| arr_wr_ok_o | output | 1 | `chk_addr_i` may be written now |
| wrsr_start_o | output | 1 | Status write accepted; launch a timed cycle |

## Verification
The bench probes every region code at the addresses just below and at each region boundary as well as the first and last address; an off-by-one decode or swapped region bits would open or close the wrong quarter. It lowers the protect pin only during the command phase and raises it again before completion, which a design that samples the pin only at completion would wrongly accept. It lowers the pin after acceptance, so a design that re-checks protection at cycle end would lose the update, and it checks the status byte between acceptance and cycle end, where a design applying bits immediately would show them early. It also tries to clear the arm bit with the pin low, and issues the disable strobe with the pin low to catch a latch clear that wrongly depends on the pin.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_lvl_e;

  localparam int ST_W      = 8;
  localparam int ST_BUSY   = 0;
  localparam int ST_WEN    = 1;
  localparam int ST_LVL_LO = 2;
  localparam int ST_LVL_HI = 3;
  localparam int ST_ARM    = 7;

  typedef struct packed {
    logic      arm;
    prot_lvl_e lvl;
  } nv_bits_t;

  function automatic logic [ST_W-1:0] pack_status(logic busy, logic wen, nv_bits_t nv);
    logic [ST_W-1:0] s;
    s = '0;
    if (busy) begin
      s = '1;
    end else begin
      s[ST_ARM]                = nv.arm;
      s[ST_LVL_HI:ST_LVL_LO]   = nv.lvl;
      s[ST_WEN]                = wen;
    end
    return s;
  endfunction

  function automatic nv_bits_t unpack_nv(logic [ST_W-1:0] d);
    nv_bits_t n;
    n.arm = d[ST_ARM];
    n.lvl = prot_lvl_e'(d[ST_LVL_HI:ST_LVL_LO]);
    return n;
  endfunction

endpackage

// File: rtl/sr_guard_wel.sv
module sr_guard_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  input  logic cyc_end_i,
  output logic wen_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_o <= 1'b0;
    end else if (cyc_end_i) begin
      wen_o <= 1'b0;
    end else if (!busy_i) begin
      if (clr_i)      wen_o <= 1'b0;
      else if (set_i) wen_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sr_guard_region.sv
module sr_guard_region #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  sr_guard_pkg::prot_lvl_e lvl_i,
  output logic                    prot_o
);
  import sr_guard_pkg::*;

  localparam int TOP = ADDR_W - 1;

  function automatic logic in_region(logic [ADDR_W-1:0] a, prot_lvl_e l);
    logic r;
    unique case (l)
      PROT_NONE:    r = 1'b0;
      PROT_QUARTER: r = a[TOP] & a[TOP-1];
      PROT_HALF:    r = a[TOP];
      default:      r = 1'b1;
    endcase
    return r;
  endfunction

  assign prot_o = in_region(addr_i, lvl_i);

endmodule

// File: rtl/sr_guard_nv.sv
module sr_guard_nv (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    open_i,
  input  logic                    go_i,
  input  logic [7:0]              data_i,
  input  logic                    hw_prot_i,
  input  logic                    sr_ok_i,
  input  logic                    cyc_end_i,
  output sr_guard_pkg::nv_bits_t  nv_o,
  output logic                    start_o,
  output logic                    cancel_o
);
  import sr_guard_pkg::*;

  logic     cancel_q;
  logic     pend_vld_q;
  nv_bits_t pend_q;
  logic     unused_data;

  assign unused_data = ^{data_i[6:4], data_i[1:0]};
  assign cancel_o    = cancel_q;
  assign start_o     = go_i & sr_ok_i & ~cancel_q;

  // Cancellation is sticky for the rest of the command phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cancel_q <= 1'b0;
    else if (go_i)                  cancel_q <= 1'b0;
    else if (open_i && hw_prot_i)   cancel_q <= 1'b1;
  end

  // Accepted bits wait for the end of the timed cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      nv_o       <= '0;
    end else begin
      if (start_o) begin
        pend_vld_q <= 1'b1;
        pend_q     <= unpack_nv(data_i);
      end else if (cyc_end_i) begin
        pend_vld_q <= 1'b0;
        if (pend_vld_q) nv_o <= pend_q;
      end
    end
  end

endmodule

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_open_i,
  input  logic              wrsr_go_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [7:0]        status_o,
  output logic              sr_wr_ok_o,
  output logic              arr_wr_ok_o,
  output logic              wrsr_start_o
);
  import sr_guard_pkg::*;

  logic     busy_q;
  logic     cyc_end;
  logic     hw_prot;
  logic     wen;
  logic     addr_prot;
  logic     cancel;
  nv_bits_t nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_i;
  end

  assign cyc_end = busy_q & ~busy_i;
  assign hw_prot = nv.arm & ~wp_n_i;

  sr_guard_wel u_wel (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (wren_i),
    .clr_i     (wrdi_i),
    .busy_i    (busy_i),
    .cyc_end_i (cyc_end),
    .wen_o     (wen)
  );

  sr_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i (chk_addr_i),
    .lvl_i  (nv.lvl),
    .prot_o (addr_prot)
  );

  sr_guard_nv u_nv (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_i    (wrsr_open_i),
    .go_i      (wrsr_go_i),
    .data_i    (wrsr_data_i),
    .hw_prot_i (hw_prot),
    .sr_ok_i   (sr_wr_ok_o),
    .cyc_end_i (cyc_end),
    .nv_o      (nv),
    .start_o   (wrsr_start_o),
    .cancel_o  (cancel)
  );

  assign sr_wr_ok_o  = wen & ~busy_i & ~hw_prot;
  assign arr_wr_ok_o = wen & ~busy_i & ~addr_prot;
  assign status_o    = pack_status(busy_i, wen, nv);

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_go_i,
  input logic       wp_n_i,
  input logic       busy_i,
  input logic [7:0] status_o,
  input logic       sr_wr_ok_o,
  input logic       arr_wr_ok_o,
  input logic       wrsr_start_o,
  input logic       cancel
);

  AST_IDLE_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));  // R2

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (!sr_wr_ok_o && !arr_wr_ok_o && status_o == 8'hFF));  // R3

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_i && !wrdi_i && !busy_i) |=> status_o[1]);  // R4

  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_i && !busy_i) |=> (busy_i || !status_o[1]));  // R4

  AST_CYCLE_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |=> (busy_i || !status_o[1]));  // R5

  AST_ARRAY_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok_o |-> (status_o[1] && !busy_i));  // R6

  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);  // R6

  AST_PIN_BLOCKS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[7] && !wp_n_i) |-> !sr_wr_ok_o);  // R7

  AST_START_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_start_o |-> (wrsr_go_i && sr_wr_ok_o));  // R8

  AST_CANCEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && wrsr_go_i) |-> !wrsr_start_o);  // R9

  AST_ARM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !$past(busy_i) && status_o[7] && !wp_n_i) |=> status_o[7]);  // R11

endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wren_i       (wren_i),
  .wrdi_i       (wrdi_i),
  .wrsr_go_i    (wrsr_go_i),
  .wp_n_i       (wp_n_i),
  .busy_i       (busy_i),
  .status_o     (status_o),
  .sr_wr_ok_o   (sr_wr_ok_o),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .wrsr_start_o (wrsr_start_o),
  .cancel       (cancel)
);

// File: tb/sr_guard_tb.sv
module sr_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int SZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren = 0, wrdi = 0, wopen = 0, wgo = 0, wp_n = 1, busy = 0;
  logic [7:0]    wdata = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0]    status;
  logic          sr_ok, arr_ok, start;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_wen = 0, m_arm = 0;
  logic [1:0] m_lvl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_open_i(wopen), .wrsr_go_i(wgo), .wrsr_data_i(wdata),
    .wp_n_i(wp_n), .busy_i(busy), .chk_addr_i(addr),
    .status_o(status), .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok),
    .wrsr_start_o(start)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_arm, 3'b000, m_lvl, m_wen, 1'b0};
  endfunction

  // protection by lower bound, stated independently of bit slicing
  function automatic bit exp_prot(int a);
    int lo;
    case (m_lvl)
      2'd0: lo = SZ;
      2'd1: lo = (SZ / 4) * 3;
      2'd2: lo = SZ / 2;
      default: lo = 0;
    endcase
    return a >= lo;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmd_wren();
    wren = 1; tick(); wren = 0;
    m_wen = 1;
  endtask

  // Full status write; late_wp drops the pin during the timed cycle
  task automatic wr_status(logic [7:0] d, bit exp_ok, bit late_wp, string req);
    wopen = 1; wdata = d; tick(); tick();
    wopen = 0; wgo = 1; #1;
    chk(req, start, exp_ok);
    tick(); wgo = 0;
    if (exp_ok) begin
      chk({req, " pending not yet visible"}, status, exp_status());
      busy = 1; tick();
      if (late_wp) wp_n = 0;
      chk("R3 busy reads all ones", status, 8'hFF);
      tick(); tick();
      busy = 0; tick();
      m_wen = 0; m_arm = d[7]; m_lvl = d[3:2];
      chk({req, " applied at cycle end, R5"}, status, exp_status());
      wp_n = 1;
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 sr_ok", sr_ok, 0);
    chk("R1 arr_ok", arr_ok, 0);
  endtask

  task automatic t_latch();
    cmd_wren();
    chk("R4 wren sets", status, exp_status());
    chk("R8 sr_ok with wen", sr_ok, 1);
    wp_n = 0; wrdi = 1; tick(); wrdi = 0; wp_n = 1; m_wen = 0;
    chk("R4 wrdi clears with pin low", status, exp_status());
    wren = 1; wrdi = 1; tick(); wren = 0; wrdi = 0;
    chk("R4 wrdi wins", status, exp_status());
  endtask

  task automatic t_busy();
    cmd_wren();
    busy = 1; #1;
    chk("R3 arr_ok off while busy", arr_ok, 0);
    chk("R3 status while busy", status, 8'hFF);
    tick(); busy = 0; tick(); m_wen = 0;
    chk("R5 wen cleared by array cycle", status, exp_status());
  endtask

  task automatic t_regions();
    for (int lv = 0; lv < 4; lv++) begin
      cmd_wren();
      wr_status({4'b0000, lv[1:0], 2'b00}, 1, 0, "R8 region write");
      cmd_wren();
      for (int k = 0; k < 6; k++) begin
        int a;
        case (k)
          0: a = 0;
          1: a = SZ/2 - 1;
          2: a = SZ/2;
          3: a = (SZ/4)*3 - 1;
          4: a = (SZ/4)*3;
          default: a = SZ - 1;
        endcase
        addr = a[AW-1:0]; #1;
        chk($sformatf("R6 lvl %0d addr 0x%0h", lv, a), arr_ok, !exp_prot(a));
      end
      wrdi = 1; tick(); wrdi = 0; m_wen = 0;
    end
  endtask

  task automatic t_hwprot();
    cmd_wren();
    wr_status(8'h84, 1, 0, "R8 arm on");
    cmd_wren();
    wp_n = 0; addr = '0; #1;
    chk("R7 sr blocked", sr_ok, 0);
    chk("R7 low addr still writable", arr_ok, 1);
    addr = '1; #1;
    chk("R7 top addr protected", arr_ok, 0);
    wr_status(8'h00, 0, 0, "R11 clear arm rejected");
    chk("R11 arm kept", status, exp_status());
    wp_n = 1; #1;
    chk("R7 pin high allows sr", sr_ok, 1);
  endtask

  task automatic t_cancel();
    // arm=1, wen=1 from previous task
    wopen = 1; wdata = 8'h00; tick();
    wp_n = 0; tick(); wp_n = 1; tick();
    wopen = 0; wgo = 1; #1;
    chk("R9 cancelled go", start, 0);
    tick(); wgo = 0;
    chk("R9 state unchanged", status, exp_status());
    wr_status(8'h84, 1, 0, "R9 retry accepted");
  endtask

  task automatic t_late_wp();
    cmd_wren();
    wr_status(8'h08, 1, 1, "R10 pin after accept ignored");
    chk("R10 arm cleared", status[7], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1; tick();
    t_reset();
    t_latch();
    t_busy();
    t_regions();
    t_hwprot();
    t_cancel();
    t_late_wp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule